// File: doc/BRIEF.md
# Vector Lane Store Unit

This unit executes a store of a single element pulled out of one lane of a 64-bit vector register. One input beat carries the instruction fields and the operand values it needs. These are the element size code, a packed lane/alignment field, the vector register number and contents, and the base and index general registers with their numbers. One cycle later the unit answers with one of two results. The first is a memory write request, with address, zero-extended little-endian data and byte enables, together with a possible base register writeback. The second is exactly one of three error indications: undefined encoding, unpredictable encoding or alignment fault.

The unit sits between operand read and the memory pipeline. Condition evaluation, enable traps, the register file and memory belong to the surrounding pipeline. The unit only decides whether the encoding is legal, whether the base address meets the requested alignment, which bytes to write, and what the new base value is.

Top module: `lane_store_unit`

## Requirements
- R1: Size code 0 selects 8-bit elements, 1 selects 16-bit elements and 2 selects 32-bit elements. Size code 3 raises `undef_o`.
- R2: For 8-bit elements, lane field bit 0 set raises `undef_o`. The lane number is field bits 3:1 (0..7), and no address alignment is required.
- R3: For 16-bit elements, lane field bit 1 set raises `undef_o`. The lane number is field bits 3:2. Field bit 0 set requires a 2-byte aligned address; clear means no alignment.
- R4: For 32-bit elements, field bit 2 set or field bits 1:0 equal to 01 or 10 raises `undef_o`. The lane number is field bit 3. Bits 1:0 = 11 require a 4-byte aligned address, and 00 requires none.
- R5: A write carries `wr_addr_o` = base value and the lane element in the low bits of `wr_data_o`, zero-extended; the element starts at bit lane × width of the vector value. `wr_be_o` is 0001, 0011 or 1111 for 1, 2 or 4 bytes.
- R6: On a legal encoding whose base address is not a multiple of the required alignment, `fault_o` is raised and no write or writeback is issued.
- R7: On a write, the writeback behaviour depends on the index register number. 15 gives no writeback. 13 gives `wb_val_o` = base + element bytes. Any other number gives base + index value. `wb_num_o` is the base register number.
- R8: Base register number 15 on a legal encoding raises `unpred_o` with no write or writeback.
- R9: At most one of `undef_o`, `unpred_o` and `fault_o` is set, with priority undefined > unpredictable > alignment. When no write is issued, `wr_data_o`, `wr_be_o`, `wb_val_o` are zero.
- R10: All outputs are registered. `out_valid_o` follows `valid_i` by one cycle, and without an input beat, the write, writeback and all flags are low.
- R11: A synchronous active-high `rst` clears all valid, write, writeback and flag outputs on the next clock edge.
- R12: `vreg_o` reports the source vector register number as {`vreg_hi_i`, `vreg_lo_i`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Input beat strobe |
| size_i | input | 2 | Element size code |
| lanefld_i | input | 4 | Packed lane number / alignment field |
| vreg_hi_i | input | 1 | High bit of vector register number |
| vreg_lo_i | input | 4 | Low four bits of vector register number |
| vec_i | input | 64 | Vector register contents |
| base_num_i | input | 4 | Base register number |
| base_val_i | input | XLEN | Base register value |
| idx_num_i | input | 4 | Index register number |
| idx_val_i | input | XLEN | Index register value |
| out_valid_o | output | 1 | Result beat strobe |
| wr_en_o | output | 1 | Memory write request |
| wr_addr_o | output | XLEN | Write byte address |
| wr_data_o | output | 32 | Write data, zero-extended element |
| wr_be_o | output | 4 | Byte enables |
| wb_en_o | output | 1 | Base writeback enable |
| wb_num_o | output | 4 | Base register to write back |
| wb_val_o | output | XLEN | New base value |
| undef_o | output | 1 | Undefined encoding |
| unpred_o | output | 1 | Unpredictable encoding (base is 15) |
| fault_o | output | 1 | Alignment fault |
| vreg_o | output | 5 | Source vector register number |

## Verification
The hardest case to reach is a successful 32-bit store that requests 4-byte alignment. It needs size 2, field bits 2:0 equal to 011, a base address with its two low bits clear and a base number other than 15, and uniform draws produce this combination rarely. The stimulus therefore biases the lane field toward the legal patterns of each size, and it clears the low address bits on a share of beats. Directed beats also pin down each illegal field pattern, the misaligned and aligned edges for both alignment hints, and the index numbers 13 and 15.

// File: rtl/lane_store_unit.sv
module lane_store_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [1:0]      size_i,
  input  logic [3:0]      lanefld_i,
  input  logic            vreg_hi_i,
  input  logic [3:0]      vreg_lo_i,
  input  logic [63:0]     vec_i,
  input  logic [3:0]      base_num_i,
  input  logic [XLEN-1:0] base_val_i,
  input  logic [3:0]      idx_num_i,
  input  logic [XLEN-1:0] idx_val_i,
  output logic            out_valid_o,
  output logic            wr_en_o,
  output logic [XLEN-1:0] wr_addr_o,
  output logic [31:0]     wr_data_o,
  output logic [3:0]      wr_be_o,
  output logic            wb_en_o,
  output logic [3:0]      wb_num_o,
  output logic [XLEN-1:0] wb_val_o,
  output logic            undef_o,
  output logic            unpred_o,
  output logic            fault_o,
  output logic [4:0]      vreg_o
);
  localparam logic [3:0] NO_WB_REG   = 4'd15;
  localparam logic [3:0] STEP_WB_REG = 4'd13;
  localparam logic [3:0] BAD_BASE    = 4'd15;

  logic        bad_enc;
  logic [5:0]  bit_off;
  logic [1:0]  amask;
  logic [3:0]  be;
  logic [2:0]  nbytes;

  always_comb begin
    bad_enc = 1'b0;
    bit_off = '0;
    amask   = 2'b00;
    be      = 4'b0000;
    nbytes  = 3'd0;
    case (size_i)
      2'd0: begin
        bad_enc = lanefld_i[0];
        bit_off = {lanefld_i[3:1], 3'b000};
        be      = 4'b0001;
        nbytes  = 3'd1;
      end
      2'd1: begin
        bad_enc = lanefld_i[1];
        bit_off = {lanefld_i[3:2], 4'b0000};
        amask   = {1'b0, lanefld_i[0]};
        be      = 4'b0011;
        nbytes  = 3'd2;
      end
      2'd2: begin
        bad_enc = lanefld_i[2] | (lanefld_i[1] ^ lanefld_i[0]);
        bit_off = {lanefld_i[3], 5'b00000};
        amask   = {2{lanefld_i[0]}};
        be      = 4'b1111;
        nbytes  = 3'd4;
      end
      default: bad_enc = 1'b1;
    endcase
  end

  logic [63:0] shifted;
  logic [31:0] byte_mask, elem;
  logic        misaligned, c_unpred, c_fault, c_write, c_wb;
  logic [XLEN-1:0] step, new_base;

  assign shifted    = vec_i >> bit_off;
  assign byte_mask  = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  assign elem       = shifted[31:0] & byte_mask;
  assign misaligned = |(base_val_i[1:0] & amask);
  assign c_unpred   = !bad_enc && (base_num_i == BAD_BASE);
  assign c_fault    = !bad_enc && !c_unpred && misaligned;
  assign c_write    = !bad_enc && !c_unpred && !misaligned;
  assign c_wb       = c_write && (idx_num_i != NO_WB_REG);
  assign step       = (idx_num_i == STEP_WB_REG) ? XLEN'(nbytes) : idx_val_i;
  assign new_base   = base_val_i + step;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_be_o     <= '0;
      wb_en_o     <= 1'b0;
      wb_num_o    <= '0;
      wb_val_o    <= '0;
      undef_o     <= 1'b0;
      unpred_o    <= 1'b0;
      fault_o     <= 1'b0;
      vreg_o      <= '0;
    end else begin
      out_valid_o <= valid_i;
      wr_en_o     <= valid_i && c_write;
      wr_addr_o   <= base_val_i;
      wr_data_o   <= (valid_i && c_write) ? elem : '0;
      wr_be_o     <= (valid_i && c_write) ? be : '0;
      wb_en_o     <= valid_i && c_wb;
      wb_num_o    <= base_num_i;
      wb_val_o    <= (valid_i && c_wb) ? new_base : '0;
      undef_o     <= valid_i && bad_enc;
      unpred_o    <= valid_i && c_unpred;
      fault_o     <= valid_i && c_fault;
      vreg_o      <= {vreg_hi_i, vreg_lo_i};
    end
  end
endmodule

// File: rtl/lane_store_unit_chk.sv
module lane_store_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_i,
  input logic            out_valid_o,
  input logic            wr_en_o,
  input logic [3:0]      wr_be_o,
  input logic [31:0]     wr_data_o,
  input logic            wb_en_o,
  input logic            undef_o,
  input logic            unpred_o,
  input logic            fault_o
);
  a_r9_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({undef_o, unpred_o, fault_o}));

  a_r9_flag_blocks_write: assert property (@(posedge clk) disable iff (rst)
    (undef_o || unpred_o || fault_o) |-> (!wr_en_o && !wb_en_o));

  a_r7_wb_needs_write: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> wr_en_o);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> out_valid_o);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!out_valid_o && !wr_en_o && !undef_o && !unpred_o && !fault_o));

  a_r5_be_shape: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_be_o == 4'b0001 || wr_be_o == 4'b0011 || wr_be_o == 4'b1111));

  a_r5_data_in_be: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> ((wr_data_o & ~{{8{wr_be_o[3]}}, {8{wr_be_o[2]}}, {8{wr_be_o[1]}}, {8{wr_be_o[0]}}}) == 32'd0));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid_o && !wr_en_o && !wb_en_o && !undef_o && !unpred_o && !fault_o));
endmodule

bind lane_store_unit lane_store_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst(rst), .valid_i(valid_i), .out_valid_o(out_valid_o),
  .wr_en_o(wr_en_o), .wr_be_o(wr_be_o), .wr_data_o(wr_data_o), .wb_en_o(wb_en_o),
  .undef_o(undef_o), .unpred_o(unpred_o), .fault_o(fault_o)
);

// File: tb/lane_store_unit_tb_top.sv
`timescale 1ns/1ps
module lane_store_unit_tb_top;
  localparam int XLEN = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic valid_i = 1'b0;
  logic [1:0] size_i = '0;
  logic [3:0] lanefld_i = '0;
  logic vreg_hi_i = 1'b0;
  logic [3:0] vreg_lo_i = '0;
  logic [63:0] vec_i = '0;
  logic [3:0] base_num_i = '0, idx_num_i = '0;
  logic [XLEN-1:0] base_val_i = '0, idx_val_i = '0;
  logic out_valid_o, wr_en_o, wb_en_o, undef_o, unpred_o, fault_o;
  logic [XLEN-1:0] wr_addr_o, wb_val_o;
  logic [31:0] wr_data_o;
  logic [3:0] wr_be_o, wb_num_o;
  logic [4:0] vreg_o;

  always #4 clk = ~clk;

  lane_store_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .size_i(size_i), .lanefld_i(lanefld_i),
    .vreg_hi_i(vreg_hi_i), .vreg_lo_i(vreg_lo_i), .vec_i(vec_i),
    .base_num_i(base_num_i), .base_val_i(base_val_i),
    .idx_num_i(idx_num_i), .idx_val_i(idx_val_i),
    .out_valid_o(out_valid_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .wb_en_o(wb_en_o),
    .wb_num_o(wb_num_o), .wb_val_o(wb_val_o), .undef_o(undef_o),
    .unpred_o(unpred_o), .fault_o(fault_o), .vreg_o(vreg_o)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected values, computed from the requirements
  logic e_v, e_wr, e_wb, e_ud, e_up, e_fl;
  logic [31:0] e_data, e_wbval;
  logic [3:0] e_be;
  string e_tag;

  task automatic model();
    int ebytes, lane, align;
    logic bad;
    bad = 1'b0; ebytes = 0; lane = 0; align = 1;
    case (size_i)
      2'd0: begin e_tag = "R2"; ebytes = 1; bad = lanefld_i[0]; lane = int'(lanefld_i[3:1]); end
      2'd1: begin e_tag = "R3"; ebytes = 2; bad = lanefld_i[1]; lane = int'(lanefld_i[3:2]);
                  align = lanefld_i[0] ? 2 : 1; end
      2'd2: begin e_tag = "R4"; ebytes = 4; lane = int'(lanefld_i[3]);
                  bad = lanefld_i[2] || !(lanefld_i[1:0] == 2'b00 || lanefld_i[1:0] == 2'b11);
                  align = (lanefld_i[1:0] == 2'b11) ? 4 : 1; end
      default: begin e_tag = "R1"; bad = 1'b1; end
    endcase
    e_v  = valid_i;
    e_ud = valid_i && bad;
    e_up = valid_i && !bad && base_num_i == 4'd15;
    e_fl = valid_i && !bad && base_num_i != 4'd15 && (base_val_i % align) != 0;
    e_wr = valid_i && !e_ud && !e_up && !e_fl;
    e_wb = e_wr && idx_num_i != 4'd15;
    e_data = '0; e_be = '0; e_wbval = '0;
    if (e_wr) begin
      for (int b = 0; b < ebytes; b++) begin
        e_data[8*b +: 8] = vec_i[lane*ebytes*8 + 8*b +: 8];
        e_be[b] = 1'b1;
      end
    end
    if (e_wb) e_wbval = base_val_i + ((idx_num_i == 4'd13) ? ebytes : idx_val_i);
  endtask

  task automatic check_out(logic [3:0] bn, logic [31:0] bv, logic [4:0] vr);
    chk("R10 out_valid", out_valid_o, e_v);
    chk({e_tag, " undef"}, undef_o, e_ud);
    chk("R8 unpred", unpred_o, e_up);
    chk("R6 fault", fault_o, e_fl);
    chk("R9 wr_en", wr_en_o, e_wr);
    chk({e_tag, " lane data"}, wr_data_o, e_data);
    chk("R5 byte enables", wr_be_o, e_be);
    chk("R7 wb_en", wb_en_o, e_wb);
    chk("R7 wb_val", wb_val_o, e_wbval);
    if (e_wr) chk("R5 address", wr_addr_o, bv);
    if (e_wb) chk("R7 wb_num", wb_num_o, bn);
    if (e_v)  chk("R12 vreg", vreg_o, vr);
  endtask

  // one beat: drive at negedge, check at the following negedge
  task automatic beat(logic v, logic [1:0] sz, logic [3:0] lf, logic [3:0] bn,
                      logic [31:0] bv, logic [3:0] in_, logic [31:0] iv);
    logic [3:0] bn_s; logic [31:0] bv_s; logic [4:0] vr_s;
    @(negedge clk);
    valid_i = v; size_i = sz; lanefld_i = lf; base_num_i = bn; base_val_i = bv;
    idx_num_i = in_; idx_val_i = iv;
    vreg_hi_i = 1'($urandom()); vreg_lo_i = 4'($urandom());
    vec_i = {$urandom(), $urandom()};
    model();
    bn_s = bn; bv_s = bv; vr_s = {vreg_hi_i, vreg_lo_i};
    @(negedge clk);
    check_out(bn_s, bv_s, vr_s);
  endtask

  initial begin
    #1500000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R11: reset with a legal beat present clears outputs
    valid_i = 1'b1; size_i = 2'd0; base_num_i = 4'd1; idx_num_i = 4'd13;
    repeat (3) @(negedge clk);
    chk("R11 out_valid in reset", out_valid_o, 1'b0);
    chk("R11 wr_en in reset", wr_en_o, 1'b0);
    chk("R11 flags in reset", {undef_o, unpred_o, fault_o, wb_en_o}, 4'd0);
    rst = 1'b0; valid_i = 1'b0;

    // directed corners
    beat(1, 2'd3, 4'h0, 4'd2, 32'h100, 4'd3, 32'h10);   // R1 size 3
    for (int lf = 0; lf < 16; lf++) begin
      beat(1, 2'd0, 4'(lf), 4'd2, 32'h1003, 4'd13, 0);  // R2 all fields
      beat(1, 2'd1, 4'(lf), 4'd2, 32'h1001, 4'd4, 32'h20); // R3, odd address
      beat(1, 2'd1, 4'(lf), 4'd2, 32'h1002, 4'd15, 0);
      beat(1, 2'd2, 4'(lf), 4'd2, 32'h1002, 4'd13, 0);  // R4 half-aligned
      beat(1, 2'd2, 4'(lf), 4'd2, 32'h1004, 4'd5, 32'hFFFFFFFC);
    end
    beat(1, 2'd2, 4'b1011, 4'd15, 32'h2000, 4'd13, 0);  // R8 over legal
    beat(1, 2'd3, 4'h0, 4'd15, 32'h2001, 4'd13, 0);     // R9 undef wins
    beat(1, 2'd1, 4'b0001, 4'd15, 32'h2001, 4'd13, 0);  // R9 unpred beats fault
    beat(0, 2'd0, 4'h0, 4'd1, 32'h0, 4'd13, 0);         // R10 idle

    // biased random
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] sz; logic [3:0] lf; logic [31:0] bv;
      sz = 2'($urandom_range(0, 3));
      lf = 4'($urandom());
      if ($urandom_range(0, 3) != 0) begin
        case (sz)
          2'd0: lf[0] = 1'b0;
          2'd1: lf[1] = 1'b0;
          2'd2: begin lf[2] = 1'b0; lf[1] = lf[0]; end
          default: ;
        endcase
      end
      bv = $urandom();
      if ($urandom_range(0, 1) != 0) bv[1:0] = 2'b00;
      beat(($urandom_range(0, 7) != 0), sz, lf, 4'($urandom()), bv,
           4'($urandom_range(0, 2) == 0 ? 13 : ($urandom_range(0, 2) == 0 ? 15 : $urandom())),
           $urandom());
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule